// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between a memory bus slave and a page-write engine. It classifies every incoming write strobe as one of three kinds: a protection command byte, a permitted data write, or a rejected write. Ordinary data writes stay locked until a three-byte unlock sequence has been written to two fixed offsets. After that, data writes are granted for as long as each byte arrives within the page byte-load window of the byte before it.

A second, five-byte command sequence opens an eight-bit block mask. The write that follows it, at any address, becomes the new mask. Each set mask bit locks out one 1K-byte block of the 8K-byte space, whatever the unlock state. An external write-lock input rejects every write while it is high. The mask is reloaded from a stored value while reset is asserted, which stands in for the non-volatile copy.

Every result is registered and appears one cycle after the write strobe. The page-write engine uses `res_allow` to commit a byte and `res_cmd` to drop a byte that was consumed as a command.

Top module: `wprot_seq`

## Requirements
- R1: While `rst` is high, `mask_q` loads `mask_init`, the tracker goes idle, and `res_valid`, `res_allow` and `res_cmd` are 0.
- R2: A data write that arrives while the tracker is idle is rejected: `res_valid`=1, `res_allow`=0, `res_cmd`=0.
- R3: The unlock sequence is 0xAA to offset 0x555, then 0x55 to offset 0xAAA, then 0xA0 to offset 0x555. Each of these bytes is reported with `res_cmd`=1 and `res_allow`=0. After the sequence, every later write to an unprotected block is reported with `res_allow`=1.
- R4: Command offsets are compared on `wr_addr[11:0]` only. The plane bit `wr_addr[12]` may take either value.
- R5: Each byte of a sequence or of an open session must arrive within `WIN_CYCLES` clock edges of the previous byte. A write that arrives `k` edges after the previous one is accepted when `k` is at most `WIN_CYCLES`. A later write finds the tracker idle.
- R6: A write that does not match the next expected command byte and offset is rejected with `res_cmd`=0, and it returns the tracker to idle.
- R7: The mask-open sequence is 0xAA@0x555, 0x55@0xAAA, 0xC0@0x555, 0xAA@0x555, 0x55@0xAAA. The next write, at any address, is reported with `res_cmd`=1. Its data appears on `mask_q` in the same cycle as the result, and the tracker then goes idle.
- R8: Mask bit n protects the addresses whose `wr_addr[12:10]` equals n (1 = protected). A write to a protected block is rejected even in an open session, and the session stays open.
- R9: A write with `wr_lock` high is rejected with `res_cmd`=0. It returns the tracker to idle and leaves `mask_q` unchanged.
- R10: `res_valid` is 1 in exactly the cycle after each cycle with `wr_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the mask from `mask_init` |
| wr_valid | input | 1 | One-cycle write strobe |
| wr_addr | input | 13 | Write byte address; bit 12 selects the plane |
| wr_data | input | 8 | Write data byte |
| wr_lock | input | 1 | External write lock; high rejects all writes |
| mask_init | input | 8 | Stored mask value restored during reset |
| res_valid | output | 1 | Result of the previous cycle's write is valid |
| res_allow | output | 1 | The write is a permitted data write |
| res_cmd | output | 1 | The write was consumed as a command byte |
| mask_q | output | 8 | Current block protect mask |

## Verification
The classification of a write is registered once, so `res_valid`, `res_allow` and `res_cmd` are due one cycle after the strobe edge. A mask update lands on `mask_q` at that same edge. The bench drives each strobe on a falling edge and reads all outputs on the next falling edge, which is exactly one rising edge later, so each result is sampled in the cycle it is due. The window limit is swept gap by gap: the inter-byte distance runs from one edge to two past `WIN_CYCLES`, which puts the expiry edge exactly where R5 places it. All 256 mask values are written through the command sequence and then probed against all eight blocks.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_G1,
    ST_G2,
    ST_OPEN,
    ST_B3,
    ST_B4,
    ST_B5
  } seq_st_t;

  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  KEY_DATA   = 8'hA0;
  localparam logic [7:0]  KEY_MASK   = 8'hC0;
  localparam logic [11:0] OFS_LOW    = 12'h555;
  localparam logic [11:0] OFS_HIGH   = 12'hAAA;

endpackage

// File: rtl/wprot_match.sv
module wprot_match
  import wprot_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int BLK_SHIFT = 10,
  parameter int NBLK      = 8,
  localparam int OFS_W    = ADDR_W - 1,
  localparam int BLK_W    = $clog2(NBLK)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit_first,
  output logic              hit_second,
  output logic              hit_data,
  output logic              hit_mask,
  output logic [BLK_W-1:0]  blk_idx
);

  logic at_low;
  logic at_high;

  // The plane bit (top address bit) takes no part in the offset compare.
  assign at_low  = (addr[OFS_W-1:0] == OFS_W'(OFS_LOW));
  assign at_high = (addr[OFS_W-1:0] == OFS_W'(OFS_HIGH));

  assign hit_first  = at_low  && (data == DATA_W'(KEY_FIRST));
  assign hit_second = at_high && (data == DATA_W'(KEY_SECOND));
  assign hit_data   = at_low  && (data == DATA_W'(KEY_DATA));
  assign hit_mask   = at_low  && (data == DATA_W'(KEY_MASK));

  assign blk_idx = addr[BLK_SHIFT +: BLK_W];

endmodule

// File: rtl/wprot_window.sv
module wprot_window #(
  parameter int WIN_CYCLES = 5000,
  localparam int CNT_W     = $clog2(WIN_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expiring
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= CNT_W'(WIN_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // The edge that would take the count to zero ends the window.
  assign expiring = (cnt_q <= CNT_W'(1));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WIN_CYCLES));

  p_cnt_rest_r5: assert property (@(posedge clk) disable iff (rst)
    (!restart && cnt_q == '0) |=> (cnt_q == '0));

  p_cnt_reload_r5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == CNT_W'(WIN_CYCLES)));

endmodule

// File: rtl/wprot_mask.sv
module wprot_mask #(
  parameter int NBLK   = 8,
  parameter int DATA_W = 8,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBLK-1:0]   mask_init,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BLK_W-1:0]  blk_idx,
  output logic              prot,
  output logic [NBLK-1:0]   mask_q
);

  for (genvar b = 0; b < NBLK; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[b] <= mask_init[b];
      end else if (we) begin
        mask_q[b] <= wdata[b];
      end
    end
  end

  assign prot = mask_q[blk_idx];

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mask_q));

endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
  import wprot_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int BLK_SHIFT  = 10,
  parameter int NBLK       = 8,
  parameter int WIN_CYCLES = 5000,
  localparam int BLK_W     = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_lock,
  input  logic [NBLK-1:0]   mask_init,
  output logic              res_valid,
  output logic              res_allow,
  output logic              res_cmd,
  output logic [NBLK-1:0]   mask_q
);

  seq_st_t          st_q, st_n;
  logic             hit_first, hit_second, hit_data, hit_mask;
  logic [BLK_W-1:0] blk_idx;
  logic             blk_prot;
  logic             expiring;
  logic             allow_n, cmd_n, mask_we;

  wprot_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT), .NBLK(NBLK)
  ) i_match (
    .addr(wr_addr), .data(wr_data),
    .hit_first(hit_first), .hit_second(hit_second),
    .hit_data(hit_data), .hit_mask(hit_mask),
    .blk_idx(blk_idx)
  );

  wprot_window #(.WIN_CYCLES(WIN_CYCLES)) i_window (
    .clk(clk), .rst(rst), .restart(wr_valid), .expiring(expiring)
  );

  wprot_mask #(.NBLK(NBLK), .DATA_W(DATA_W)) i_mask (
    .clk(clk), .rst(rst), .mask_init(mask_init),
    .we(mask_we), .wdata(wr_data), .blk_idx(blk_idx),
    .prot(blk_prot), .mask_q(mask_q)
  );

  always_comb begin
    st_n    = st_q;
    allow_n = 1'b0;
    cmd_n   = 1'b0;
    mask_we = 1'b0;
    if (wr_valid) begin
      if (wr_lock) begin
        st_n = ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (hit_first) begin st_n = ST_G1; cmd_n = 1'b1; end
          ST_G1: begin
            if (hit_second) begin st_n = ST_G2; cmd_n = 1'b1; end
            else st_n = ST_IDLE;
          end
          ST_G2: begin
            if (hit_data)      begin st_n = ST_OPEN; cmd_n = 1'b1; end
            else if (hit_mask) begin st_n = ST_B3;   cmd_n = 1'b1; end
            else st_n = ST_IDLE;
          end
          ST_OPEN: allow_n = !blk_prot;
          ST_B3: begin
            if (hit_first) begin st_n = ST_B4; cmd_n = 1'b1; end
            else st_n = ST_IDLE;
          end
          ST_B4: begin
            if (hit_second) begin st_n = ST_B5; cmd_n = 1'b1; end
            else st_n = ST_IDLE;
          end
          ST_B5: begin
            mask_we = 1'b1;
            cmd_n   = 1'b1;
            st_n    = ST_IDLE;
          end
          default: st_n = ST_IDLE;
        endcase
      end
    end else if (expiring) begin
      st_n = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      res_valid <= 1'b0;
      res_allow <= 1'b0;
      res_cmd   <= 1'b0;
    end else begin
      st_q      <= st_n;
      res_valid <= wr_valid;
      res_allow <= allow_n;
      res_cmd   <= cmd_n;
    end
  end

  p_lock_rejects_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_lock) |=> (!res_allow && !res_cmd && st_q == ST_IDLE));

  p_lock_keeps_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_lock) |=> $stable(mask_q));

  p_protected_denied_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && blk_prot) |=> !res_allow);

  p_idle_denies_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && st_q == ST_IDLE) |=> !res_allow);

  p_result_due_r10: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> res_valid);

  p_no_stray_result_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> (!res_valid && !res_allow && !res_cmd));

  p_one_kind_r3: assert property (@(posedge clk) disable iff (rst)
    !(res_allow && res_cmd));

  p_mask_only_on_write_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(mask_q));

endmodule

// File: tb/test_wprot_seq.sv
module test_wprot_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 8;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_lock;
  logic [7:0]  mask_init;
  logic        res_valid, res_allow, res_cmd;
  logic [7:0]  mask_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic g_valid, g_allow, g_cmd;

  wprot_seq #(.WIN_CYCLES(WIN)) i_wprot_seq (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_lock(wr_lock), .mask_init(mask_init),
    .res_valid(res_valid), .res_allow(res_allow), .res_cmd(res_cmd),
    .mask_q(mask_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one write on a falling edge; its result is read one rising edge later.
  task automatic wr(input logic [12:0] a, input logic [7:0] d, input int idle,
                    input logic lock = 1'b0);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_lock = lock;
    @(negedge clk);
    g_valid = res_valid; g_allow = res_allow; g_cmd = res_cmd;
    wr_valid = 1'b0; wr_lock = 1'b0;
    for (int i = 0; i < idle; i++) @(negedge clk);
  endtask

  task automatic expect_res(input string tag, input logic al, input logic cm);
    chk({tag, " valid"}, int'(g_valid), 1);
    chk({tag, " allow"}, int'(g_allow), int'(al));
    chk({tag, " cmd"},   int'(g_cmd),   int'(cm));
  endtask

  function automatic logic [12:0] ofs(input logic p, input logic [11:0] o);
    return {p, o};
  endfunction

  task automatic unlock(input logic p);
    wr(ofs(p, 12'h555), 8'hAA, 0); expect_res("R3 key1", 1'b0, 1'b1);
    wr(ofs(p, 12'hAAA), 8'h55, 0); expect_res("R3 key2", 1'b0, 1'b1);
    wr(ofs(p, 12'h555), 8'hA0, 0); expect_res("R3 key3", 1'b0, 1'b1);
  endtask

  task automatic set_mask(input logic p, input logic [7:0] m);
    wr(ofs(p, 12'h555), 8'hAA, 0);
    wr(ofs(p, 12'hAAA), 8'h55, 0);
    wr(ofs(p, 12'h555), 8'hC0, 0);
    wr(ofs(p, 12'h555), 8'hAA, 0);
    wr(ofs(p, 12'hAAA), 8'h55, 0); expect_res("R7 open5", 1'b0, 1'b1);
    wr(13'h0123 ^ {5'd0, m}, m, 0);
    expect_res("R7 maskbyte", 1'b0, 1'b1);
    chk("R7 mask_q", int'(mask_q), int'(m));
  endtask

  task automatic settle();
    for (int i = 0; i < WIN + 2; i++) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    wr_lock = 1'b0; mask_init = 8'h5A;
    g_valid = 0; g_allow = 0; g_cmd = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mask_q", int'(mask_q), 8'h5A);
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 res_allow", int'(res_allow), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 idle no result", int'(res_valid), 0);

    // R2: data write while idle
    wr(13'h0010, 8'h3C, 1); expect_res("R2 idle data", 1'b0, 1'b0);
    chk("R10 single result", int'(res_valid), 0);

    // R8 with restored mask 0x5A: block 1 protected, block 0 open, session stays open
    unlock(1'b0);
    wr(13'h0400, 8'h11, 0); expect_res("R8 prot blk1", 1'b0, 1'b0);
    wr(13'h0001, 8'h22, 0); expect_res("R8 open after reject", 1'b1, 1'b0);
    settle();

    // R5: gap sweep between first and second key
    for (int g = 0; g <= WIN + 1; g++) begin
      wr(13'h0555, 8'hAA, g);
      wr(13'h0AAA, 8'h55, 0);
      expect_res("R5 gap", 1'b0, (g + 1 <= WIN));
      wr(13'h0000, 8'h00, 0);
      settle();
    end
    // R5: open session expires after WIN idle edges
    unlock(1'b0);
    wr(13'h0002, 8'h01, WIN - 1); expect_res("R5 open write", 1'b1, 1'b0);
    wr(13'h0003, 8'h02, 0);       expect_res("R5 at limit", 1'b1, 1'b0);
    wr(13'h0004, 8'h03, WIN);     expect_res("R5 before lapse", 1'b1, 1'b0);
    wr(13'h0005, 8'h04, 0);       expect_res("R5 lapsed", 1'b0, 1'b0);
    settle();

    // R6: mismatch returns to idle
    wr(13'h0555, 8'hAA, 0);
    wr(13'h0123, 8'h55, 0); expect_res("R6 bad addr", 1'b0, 1'b0);
    wr(13'h0AAA, 8'h55, 0); expect_res("R6 now idle", 1'b0, 1'b0);
    wr(13'h0555, 8'hAA, 0);
    wr(13'h0AAA, 8'h55, 0);
    wr(13'h0555, 8'hA1, 0); expect_res("R6 bad data", 1'b0, 1'b0);
    wr(13'h0100, 8'h00, 0); expect_res("R6 no open", 1'b0, 1'b0);
    settle();

    // R9: write lock
    wr(13'h0555, 8'hAA, 0);
    wr(13'h0AAA, 8'h55, 0);
    wr(13'h0555, 8'hA0, 0, 1'b1); expect_res("R9 locked key", 1'b0, 1'b0);
    wr(13'h0000, 8'h77, 0);       expect_res("R9 back idle", 1'b0, 1'b0);
    unlock(1'b0);
    wr(13'h0000, 8'h77, 0, 1'b1); expect_res("R9 locked data", 1'b0, 1'b0);
    settle();
    wr(13'h0555, 8'hAA, 0); wr(13'h0AAA, 8'h55, 0); wr(13'h0555, 8'hC0, 0);
    wr(13'h0555, 8'hAA, 0); wr(13'h0AAA, 8'h55, 0);
    wr(13'h0000, 8'hFF, 0, 1'b1); expect_res("R9 locked mask", 1'b0, 1'b0);
    chk("R9 mask kept", int'(mask_q), 8'h5A);
    settle();

    // R7/R8: every mask value against every block; R4: alternate planes
    for (int m = 0; m < 256; m++) begin
      set_mask(m[0], m[7:0]);
      wr(13'h0000, 8'h00, 0); expect_res("R7 tracker idle", 1'b0, 1'b0);
      unlock(m[1]);
      for (int b = 0; b < 8; b++) begin
        wr({b[2:0], 10'h0AB}, 8'h5E, 0);
        expect_res("R8 block", !m[b], 1'b0);
      end
      settle();
    end

    // R4: plane 1 command offsets with an empty mask
    set_mask(1'b0, 8'h00);
    unlock(1'b1);
    wr(13'h1555, 8'h99, 0); expect_res("R4 plane1 data", 1'b1, 1'b0);
    settle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule